// File: doc/BRIEF.md
# Prioritized Interrupt Level Encoder

This block sits on a board-control bus. It collects thirteen level-sensitive interrupt request lines and turns them into one 4-bit interrupt level for the processor. Each request line has a fixed priority level and its own bit position in a 16-bit pending vector. A software-writable enable mask gates that vector.

The lowest-numbered level among the requests that are both pending and enabled wins. Its number is bit-inverted before it is driven out, so a quiet system presents 0 and the most urgent source presents 15.

A small register window on a one-cycle synchronous bus holds four 16-bit registers:
- the enable mask;
- a power-off control word;
- a general output word;
- a constant identification value.

Top module: `intr_lvl_ctrl`

## Requirements
- R1: After reset the enable mask, power-off word and output word are all zero, `lvl_o` is 0 and `bus_rdata` is 0.
- R2: Request input `req_i[k]` is the source of priority level k, and occupies this pending/mask bit position:

  | Level k | 0 | 1 | 2 | 3 | 4 | 5 | 6 | 7 | 8 | 9 | 10 | 11 | 12 |
  |---|---|---|---|---|---|---|---|---|---|---|---|---|---|
  | Bit position | 11 | 9 | 8 | 12 | 10 | 6 | 5 | 4 | 7 | 14 | 13 | 0 | 15 |

  Pending bits 1, 2 and 3 are never set.
- R3: A pending bit follows its request line's level with no latching. When a request drops, it no longer affects the output.
- R4: The chosen level is the smallest k whose request is high and whose mask bit is 1, or 15 when there is none. `lvl_o` equals the chosen level XOR 15, so the values 1 and 2 never appear.
- R5: `lvl_o` is a register. It reflects the requests sampled at the previous clock edge. A mask write sampled at edge E first shows in `lvl_o` after edge E+1.
- R6: Byte offset 0x00 is the enable mask. It is read/write and changes only when written there.
- R7: Offset 0x30 (power-off word) and offset 0x36 (output word) are independent read/write storage.
- R8: Offset 0x32 always reads 0x0010. Writes to it change nothing.
- R9: Reads of any other offset in the 6-bit window return 0. Writes to other offsets change no register and do not change `lvl_o`.
- R10: A read presented at an edge returns its data on `bus_rdata` after that edge. In any cycle without a read, `bus_rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 13 | Request lines, index = priority level |
| bus_sel | input | 1 | Bus access this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte offset in the window |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| lvl_o | output | 4 | Inverted winning level |

## Verification
Each source is raised alone with every mask bit enabled, which confirms its level code. With all requests high and a single mask bit enabled, each source is isolated again, which confirms the bit-position table independently of priority. Every pair of sources is then tried under several pseudo-random masks. These runs separate a true minimum-level choice from a source-order or mask-order choice, and show whether disabling the winner lets the other source of the pair through. Timing probes sample one cycle early after request and mask changes, to tell the registered path from a combinational or doubly delayed one.

// File: rtl/intr_lvl_pkg.sv
package intr_lvl_pkg;

  localparam int NSRC = 13;
  localparam int DW   = 16;
  localparam int AW   = 6;
  localparam int LW   = 4;

  localparam logic [LW-1:0] LVL_NONE = LW'((1 << LW) - 1);

  // Pending/mask bit position of the source at a given priority level.
  function automatic int src_bit(int lvl);
    case (lvl)
      0:       return 11;
      1:       return 9;
      2:       return 8;
      3:       return 12;
      4:       return 10;
      5:       return 6;
      6:       return 5;
      7:       return 4;
      8:       return 7;
      9:       return 14;
      10:      return 13;
      11:      return 0;
      12:      return 15;
      default: return 0;
    endcase
  endfunction

  // Lowest set index of the active vector; LVL_NONE if nothing is set.
  function automatic logic [LW-1:0] pick_lowest(logic [NSRC-1:0] act);
    logic [LW-1:0] r;
    r = LVL_NONE;
    for (int k = NSRC - 1; k >= 0; k--) begin
      if (act[k]) r = LW'(k);
    end
    return r;
  endfunction

  // Output coding: the chosen level inverted bit by bit.
  function automatic logic [LW-1:0] encode_lvl(logic [LW-1:0] lvl);
    return lvl ^ LVL_NONE;
  endfunction

endpackage

// File: rtl/intr_lvl_map.sv
module intr_lvl_map
  import intr_lvl_pkg::*;
(
  input  logic [NSRC-1:0] req_i,
  output logic [DW-1:0]   pend_o
);

  // Pending vector is a pure scatter of the live request levels.
  always_comb begin
    pend_o = '0;
    for (int k = 0; k < NSRC; k++) begin
      pend_o[src_bit(k)] = req_i[k];
    end
  end

endmodule

// File: rtl/intr_lvl_prio.sv
module intr_lvl_prio
  import intr_lvl_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [DW-1:0]   pend_i,
  input  logic [DW-1:0]   mask_i,
  output logic [NSRC-1:0] act_o,
  output logic [LW-1:0]   lvl_o
);

  // Per-level qualification: pending and enabled at the same position.
  for (genvar k = 0; k < NSRC; k++) begin : g_act
    localparam int BP = src_bit(k);
    assign act_o[k] = pend_i[BP] & mask_i[BP];
  end

  logic [LW-1:0] lvl_d;
  assign lvl_d = encode_lvl(pick_lowest(act_o));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_o <= '0;
    else        lvl_o <= lvl_d;
  end

endmodule

// File: rtl/intr_lvl_regs.sv
module intr_lvl_regs
  import intr_lvl_pkg::*;
#(
  parameter logic [AW-1:0] OFS_MASK  = 6'h00,
  parameter logic [AW-1:0] OFS_PWR   = 6'h30,
  parameter logic [AW-1:0] OFS_VER   = 6'h32,
  parameter logic [AW-1:0] OFS_OPORT = 6'h36,
  parameter logic [DW-1:0] VER_VAL   = 16'h0010
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic [DW-1:0] mask_o
);

  logic [DW-1:0] mask_q, pwr_q, oport_q;
  logic          wr_en, rd_en;
  logic          hit_mask, hit_pwr, hit_oport, hit_ver;
  logic [DW-1:0] rd_mux;

  assign wr_en     = bus_sel &  bus_we;
  assign rd_en     = bus_sel & ~bus_we;
  assign hit_mask  = (bus_addr == OFS_MASK);
  assign hit_pwr   = (bus_addr == OFS_PWR);
  assign hit_oport = (bus_addr == OFS_OPORT);
  assign hit_ver   = (bus_addr == OFS_VER);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q  <= '0;
      pwr_q   <= '0;
      oport_q <= '0;
    end else if (wr_en) begin
      if (hit_mask)  mask_q  <= bus_wdata;
      if (hit_pwr)   pwr_q   <= bus_wdata;
      if (hit_oport) oport_q <= bus_wdata;
    end
  end

  always_comb begin
    rd_mux = '0;
    if (hit_mask)  rd_mux = mask_q;
    if (hit_pwr)   rd_mux = pwr_q;
    if (hit_oport) rd_mux = oport_q;
    if (hit_ver)   rd_mux = VER_VAL;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     bus_rdata <= '0;
    else if (rd_en) bus_rdata <= rd_mux;
    else            bus_rdata <= '0;
  end

  assign mask_o = mask_q;

endmodule

// File: rtl/intr_lvl_ctrl.sv
module intr_lvl_ctrl
  import intr_lvl_pkg::*;
#(
  parameter logic [DW-1:0] VER_VAL = 16'h0010
)(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] req_i,
  input  logic            bus_sel,
  input  logic            bus_we,
  input  logic [AW-1:0]   bus_addr,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  output logic [LW-1:0]   lvl_o
);

  logic [DW-1:0]   pend_w;
  logic [DW-1:0]   mask_q;
  logic [NSRC-1:0] act_w;

  intr_lvl_map u_map (
    .req_i  (req_i),
    .pend_o (pend_w)
  );

  intr_lvl_regs #(.VER_VAL(VER_VAL)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .mask_o    (mask_q)
  );

  intr_lvl_prio u_prio (
    .clk    (clk),
    .rst_n  (rst_n),
    .pend_i (pend_w),
    .mask_i (mask_q),
    .act_o  (act_w),
    .lvl_o  (lvl_o)
  );

endmodule

// File: rtl/intr_lvl_chk.sv
module intr_lvl_chk
  import intr_lvl_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            bus_sel,
  input logic            bus_we,
  input logic [AW-1:0]   bus_addr,
  input logic [DW-1:0]   bus_rdata,
  input logic [LW-1:0]   lvl_o,
  input logic [DW-1:0]   pend,
  input logic [DW-1:0]   mask_q,
  input logic [NSRC-1:0] act
);

  logic rd_ver, rd_known;
  assign rd_ver   = bus_sel && !bus_we && bus_addr == 6'h32;
  assign rd_known = bus_addr == 6'h00 || bus_addr == 6'h30 ||
                    bus_addr == 6'h32 || bus_addr == 6'h36;

  a_r2_unused_pend: assert property (@(posedge clk) disable iff (!rst_n)
    pend[3:1] == 3'b000);

  a_r3_no_pending_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (pend == '0) |=> (lvl_o == '0));

  a_r4_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (act == '0) |=> (lvl_o == '0));

  a_r4_top_wins: assert property (@(posedge clk) disable iff (!rst_n)
    act[0] |=> (lvl_o == 4'hF));

  a_r4_no_odd_codes: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_o != 4'd1) && (lvl_o != 4'd2));

  a_r6_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_sel && bus_we && bus_addr == 6'h00) |=> $stable(mask_q));

  a_r8_version: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ver |=> (bus_rdata == 16'h0010));

  a_r9_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_we && !rd_known) |=> (bus_rdata == '0));

  a_r10_idle_rdata: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_sel && !bus_we) |=> (bus_rdata == '0));

endmodule

bind intr_lvl_ctrl intr_lvl_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_sel   (bus_sel),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_rdata (bus_rdata),
  .lvl_o     (lvl_o),
  .pend      (pend_w),
  .mask_q    (mask_q),
  .act       (act_w)
);

// File: tb/sim_intr_lvl_ctrl.sv
`timescale 1ns/1ps
module sim_intr_lvl_ctrl;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [12:0] req;
  logic        sel, we;
  logic [5:0]  addr;
  logic [15:0] wdata;
  logic [15:0] rdata;
  logic [3:0]  lvl;

  int errs = 0;
  int checks = 0;
  bit done = 1'b0;
  int POS [13] = '{11, 9, 8, 12, 10, 6, 5, 4, 7, 14, 13, 0, 15};

  always #2.5 clk = ~clk;

  intr_lvl_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .req_i(req), .bus_sel(sel), .bus_we(we),
    .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata), .lvl_o(lvl)
  );

  function automatic logic [3:0] ref_lvl(logic [12:0] r, logic [15:0] m);
    int best;
    best = 15;
    for (int s = 12; s >= 0; s--) if (r[s] && m[POS[s]]) best = s;
    return 4'(best ^ 15);
  endfunction

  task automatic chk(string rq, string what, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s: actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  task automatic bus_wr(logic [5:0] a, logic [15:0] d);
    @(negedge clk); sel = 1; we = 1; addr = a; wdata = d;
    @(negedge clk); sel = 0; we = 0;
  endtask

  task automatic bus_rd(logic [5:0] a, output logic [15:0] d);
    @(negedge clk); sel = 1; we = 0; addr = a;
    @(negedge clk); sel = 0; d = rdata;
  endtask

  task automatic t_reset;
    logic [15:0] d;
    chk("R1", "lvl after reset", 16'(lvl), 16'h0);
    chk("R1", "rdata after reset", rdata, 16'h0);
    bus_rd(6'h00, d); chk("R1", "mask reset", d, 16'h0);
    bus_rd(6'h30, d); chk("R1", "power-off reset", d, 16'h0);
    bus_rd(6'h36, d); chk("R1", "output word reset", d, 16'h0);
  endtask

  task automatic t_single;
    bus_wr(6'h00, 16'hFFFF);
    for (int k = 0; k < 13; k++) begin
      req = 13'(1 << k);
      @(negedge clk);
      chk("R4", $sformatf("single source %0d", k), 16'(lvl), 16'(k ^ 15));
    end
    req = '0; @(negedge clk);
  endtask

  task automatic t_mask_positions;
    req = '1;
    for (int k = 0; k < 13; k++) begin
      bus_wr(6'h00, 16'(1 << POS[k]));
      @(negedge clk);
      chk("R2", $sformatf("mask bit %0d selects level %0d", POS[k], k), 16'(lvl), 16'(k ^ 15));
    end
    bus_wr(6'h00, 16'h000E);
    @(negedge clk);
    chk("R2", "unused mask bits select nothing", 16'(lvl), 16'h0);
    req = '0; @(negedge clk);
  endtask

  task automatic t_pairs;
    logic [15:0] m;
    int bad;
    m = 16'hACE1;
    for (int r = 0; r < 4; r++) begin
      m = {m[14:0], m[15] ^ m[13] ^ m[12] ^ m[10]};
      bus_wr(6'h00, m);
      @(negedge clk);
      bad = 0;
      for (int i = 0; i < 13; i++) begin
        for (int j = i + 1; j < 13; j++) begin
          req = 13'((1 << i) | (1 << j));
          @(negedge clk);
          checks++;
          if (lvl !== ref_lvl(req, m)) begin
            errs++; bad++;
            $display("FAIL R4 pair %0d,%0d mask %h: actual=%h expected=%h", i, j, m, lvl, ref_lvl(req, m));
          end
        end
      end
    end
    req = '0; @(negedge clk);
  endtask

  task automatic t_no_latch;
    bus_wr(6'h00, 16'hFFFF);
    req = 13'(1 << 5); @(negedge clk);
    chk("R3", "level 5 raised", 16'(lvl), 16'd10);
    req = '0; @(negedge clk);
    chk("R3", "level 5 dropped", 16'(lvl), 16'd0);
    req = 13'((1 << 2) | (1 << 7)); @(negedge clk);
    chk("R3", "levels 2 and 7", 16'(lvl), 16'd13);
    req = 13'(1 << 7); @(negedge clk);
    chk("R3", "level 2 dropped", 16'(lvl), 16'd8);
    req = '0; @(negedge clk);
  endtask

  task automatic t_timing;
    req = 13'(1 << 0);
    #1 chk("R5", "no output before edge", 16'(lvl), 16'd0);
    @(negedge clk);
    chk("R5", "output after one edge", 16'(lvl), 16'd15);
    req = '1;
    bus_wr(6'h00, 16'h0000);
    @(negedge clk);
    chk("R5", "mask cleared", 16'(lvl), 16'd0);
    bus_wr(6'h00, 16'(1 << POS[12]));
    chk("R5", "mask write not yet visible", 16'(lvl), 16'd0);
    @(negedge clk);
    chk("R5", "mask write visible next edge", 16'(lvl), 16'd3);
    req = '0; @(negedge clk);
  endtask

  task automatic t_regs;
    logic [15:0] d;
    bus_wr(6'h30, 16'h1234);
    bus_wr(6'h36, 16'hABCD);
    bus_wr(6'h00, 16'h0F0F);
    bus_rd(6'h30, d); chk("R7", "power-off readback", d, 16'h1234);
    bus_rd(6'h36, d); chk("R7", "output word readback", d, 16'hABCD);
    bus_rd(6'h00, d); chk("R6", "mask readback", d, 16'h0F0F);
  endtask

  task automatic t_version;
    logic [15:0] d;
    bus_rd(6'h32, d); chk("R8", "version value", d, 16'h0010);
    bus_wr(6'h32, 16'hFFFF);
    bus_rd(6'h32, d); chk("R8", "version after write", d, 16'h0010);
    bus_rd(6'h30, d); chk("R8", "write to version spares power-off", d, 16'h1234);
  endtask

  task automatic t_unmapped;
    logic [15:0] d;
    req = '1;
    @(negedge clk);
    bus_wr(6'h02, 16'hFFFF);
    bus_wr(6'h3E, 16'hFFFF);
    bus_wr(6'h31, 16'hFFFF);
    bus_wr(6'h01, 16'hFFFF);
    @(negedge clk);
    chk("R9", "level unchanged by stray writes", 16'(lvl), 16'(ref_lvl('1, 16'h0F0F)));
    bus_rd(6'h02, d); chk("R9", "read 0x02", d, 16'h0);
    bus_rd(6'h3E, d); chk("R9", "read 0x3E", d, 16'h0);
    bus_rd(6'h01, d); chk("R9", "read 0x01", d, 16'h0);
    bus_rd(6'h00, d); chk("R9", "mask untouched", d, 16'h0F0F);
    bus_rd(6'h36, d); chk("R9", "output word untouched", d, 16'hABCD);
    req = '0; @(negedge clk);
  endtask

  task automatic t_rdata_timing;
    @(negedge clk); sel = 1; we = 0; addr = 6'h36;
    #1 chk("R10", "rdata before read edge", rdata, 16'h0);
    @(negedge clk); sel = 0;
    chk("R10", "rdata after read edge", rdata, 16'hABCD);
    @(negedge clk);
    chk("R10", "rdata idle", rdata, 16'h0);
  endtask

  initial begin
    rst_n = 0; req = '0; sel = 0; we = 0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_single();
    t_mask_positions();
    t_pairs();
    t_no_latch();
    t_timing();
    t_regs();
    t_version();
    t_unmapped();
    t_rdata_timing();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errs++; checks++;
      $display("FAIL all watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

endmodule